// File: doc/BRIEF.md
# Bunch-Crossing and Trigger-Event Identifier Tagger

This block keeps the two identifiers that one front-end unit attaches to its event data. The first is a bunch-crossing number that advances on every bunch clock. It returns to zero after a full machine orbit, and it is also cleared by a once-per-orbit bunch reset. That reset passes through a delay that software can set, so the count lines up with the crossing whose data reaches the derandomizer input. The second is an event number that advances only on level-0 accepts. It has its own clear pulse.

On each accept strobe the block captures the pair of counter values for that cycle and presents them as a tag for one cycle. A header from another fragment can also be presented. Its two identifiers are compared with the most recent local tag. Any difference sets a sticky mismatch flag, which a clear strobe releases. A saturating counter records how many mismatching headers were seen.

Top module: `bx_evt_tagger`

## Requirements
- R1: The bunch number increases by one on every clock. After it holds ORBIT_LEN-1 (default 3563) it becomes 0 on the next clock when no bunch reset takes effect.
- R2: A bunch-reset pulse sampled at a clock edge clears the bunch number at the edge that comes `bres_dly_i` clocks later. A delay of 0 clears it at the same edge. The delay range is 0 to 2^DLY_W-1.
- R3: The event number increases by one for each sampled accept and wraps from 2^EVID_W-1 to 0. It is unchanged on clocks without an accept.
- R4: An event-reset pulse clears the event number at the next edge. When the pulse arrives together with an accept, the tag carries the value before the clear, and the next accept is tagged 0.
- R5: An accept sampled at an edge makes `tag_valid_o` high for the following cycle only. In that cycle `tag_bid_o` and `tag_evid_o` hold the bunch and event numbers that were current during the accept cycle. Both fields keep their value until the next accept.
- R6: A header sampled with `hdr_valid_i` high is compared with the current tag fields. If either identifier differs, `mismatch_o` is high from the next cycle. It stays high until it is cleared.
- R7: `err_cnt_o` increases by one for each mismatching header and saturates at 2^ERR_W-1. It does not change for matching headers or when no header is presented.
- R8: `err_clr_i` clears `mismatch_o` at the next edge and does not change `err_cnt_o`. If a mismatching header arrives in the same cycle, the flag stays set.
- R9: After reset all outputs are zero, and the bunch and event numbers start from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bunch_rst_i | input | 1 | Once-per-orbit bunch-counter clear pulse |
| event_rst_i | input | 1 | Event-counter clear pulse |
| bres_dly_i | input | DLY_W | Alignment delay for the bunch clear, in clocks |
| accept_i | input | 1 | Level-0 accept strobe |
| hdr_valid_i | input | 1 | Remote header present |
| hdr_bid_i | input | BID_W | Remote bunch number |
| hdr_evid_i | input | EVID_W | Remote event number |
| err_clr_i | input | 1 | Clears the sticky mismatch flag |
| tag_valid_o | output | 1 | Tag word valid for one cycle |
| tag_bid_o | output | BID_W | Captured bunch number |
| tag_evid_o | output | EVID_W | Captured event number |
| mismatch_o | output | 1 | Sticky identifier mismatch flag |
| err_cnt_o | output | ERR_W | Saturating mismatch count |

## Verification
An off-by-one in the delay line or in the wrap point of the bunch counter moves every later tag by a fixed amount. It shows in the first tag after a bunch reset, one cycle after the accept. An event counter that counts the wrong pulses, or clears in the wrong order, gives a wrong `tag_evid_o` on the next accept. A flag that is not sticky, or a clear that also resets the count, shows at `mismatch_o` or `err_cnt_o` one cycle after the header or the clear strobe.

// File: rtl/bxt_pkg.sv
package bxt_pkg;
    localparam int BXT_BID_W     = 12;
    localparam int BXT_ORBIT_LEN = 3564;
    localparam int BXT_EVID_W    = 8;
    localparam int BXT_DLY_W     = 4;
    localparam int BXT_ERR_W     = 16;
endpackage

// File: rtl/bxt_pulse_delay.sv
module bxt_pulse_delay #(
    parameter int DLY_W = bxt_pkg::BXT_DLY_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pulse_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             pulse_o
);
    localparam int MAXD = (1 << DLY_W) - 1;

    logic [MAXD-1:0] line_d, line_q;
    logic [MAXD:0]   taps;

    always_comb begin
        line_d  = {line_q[MAXD-2:0], pulse_i};
        taps    = {line_q, pulse_i};
        pulse_o = taps[dly_i];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) line_q <= '0;
        else         line_q <= line_d;
    end
endmodule

// File: rtl/bxt_counters.sv
module bxt_counters #(
    parameter int BID_W     = bxt_pkg::BXT_BID_W,
    parameter int ORBIT_LEN = bxt_pkg::BXT_ORBIT_LEN,
    parameter int EVID_W    = bxt_pkg::BXT_EVID_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bclr_i,
    input  logic              eclr_i,
    input  logic              accept_i,
    output logic              tag_valid_o,
    output logic [BID_W-1:0]  tag_bid_o,
    output logic [EVID_W-1:0] tag_evid_o
);
    localparam logic [BID_W-1:0] BID_LAST = BID_W'(ORBIT_LEN - 1);

    typedef struct packed {
        logic [BID_W-1:0]  bid;
        logic [EVID_W-1:0] evid;
        logic              tag_v;
        logic [BID_W-1:0]  tag_bid;
        logic [EVID_W-1:0] tag_evid;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bclr_i || st_q.bid == BID_LAST) st_d.bid = '0;
        else                                st_d.bid = st_q.bid + 1'b1;
        st_d.tag_v = accept_i;
        if (accept_i) begin
            st_d.tag_bid  = st_q.bid;
            st_d.tag_evid = st_q.evid;
            st_d.evid     = st_q.evid + 1'b1;
        end
        if (eclr_i) st_d.evid = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tag_valid_o = st_q.tag_v;
    assign tag_bid_o   = st_q.tag_bid;
    assign tag_evid_o  = st_q.tag_evid;

    // R1
    bid_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.bid == BID_LAST) |=> (st_q.bid == '0));
    // R1
    bid_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bclr_i && st_q.bid != BID_LAST) |=> (st_q.bid == BID_W'($past(st_q.bid) + 1)));
    // R2
    bid_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bclr_i |=> (st_q.bid == '0));
    // R3
    evid_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && !eclr_i) |=> (st_q.evid == EVID_W'($past(st_q.evid) + 1)));
    // R3
    evid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!accept_i && !eclr_i) |=> $stable(st_q.evid));
    // R5
    tag_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |=> tag_valid_o);
    // R5
    tag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept_i |=> (!tag_valid_o && $stable(tag_bid_o) && $stable(tag_evid_o)));
endmodule

// File: rtl/bxt_pair_check.sv
module bxt_pair_check #(
    parameter int BID_W  = bxt_pkg::BXT_BID_W,
    parameter int EVID_W = bxt_pkg::BXT_EVID_W,
    parameter int ERR_W  = bxt_pkg::BXT_ERR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BID_W-1:0]  loc_bid_i,
    input  logic [EVID_W-1:0] loc_evid_i,
    input  logic              hdr_valid_i,
    input  logic [BID_W-1:0]  hdr_bid_i,
    input  logic [EVID_W-1:0] hdr_evid_i,
    input  logic              clr_i,
    output logic              mismatch_o,
    output logic [ERR_W-1:0]  err_cnt_o
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             flag;
        logic [ERR_W-1:0] cnt;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    bad;

    always_comb begin
        bad  = hdr_valid_i && ((hdr_bid_i != loc_bid_i) || (hdr_evid_i != loc_evid_i));
        st_d = st_q;
        if (bad) begin
            st_d.flag = 1'b1;
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mismatch_o = st_q.flag;
    assign err_cnt_o  = st_q.cnt;

    // R6
    sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mismatch_o && !clr_i) |=> mismatch_o);
    // R7
    cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hdr_valid_i |=> $stable(err_cnt_o));
    // R7
    cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_cnt_o == CNT_MAX) |=> (err_cnt_o == CNT_MAX));
    // R8
    clr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !hdr_valid_i) |=> (!mismatch_o && $stable(err_cnt_o)));
endmodule

// File: rtl/bx_evt_tagger.sv
module bx_evt_tagger #(
    parameter int BID_W     = bxt_pkg::BXT_BID_W,
    parameter int ORBIT_LEN = bxt_pkg::BXT_ORBIT_LEN,
    parameter int EVID_W    = bxt_pkg::BXT_EVID_W,
    parameter int DLY_W     = bxt_pkg::BXT_DLY_W,
    parameter int ERR_W     = bxt_pkg::BXT_ERR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bunch_rst_i,
    input  logic              event_rst_i,
    input  logic [DLY_W-1:0]  bres_dly_i,
    input  logic              accept_i,
    input  logic              hdr_valid_i,
    input  logic [BID_W-1:0]  hdr_bid_i,
    input  logic [EVID_W-1:0] hdr_evid_i,
    input  logic              err_clr_i,
    output logic              tag_valid_o,
    output logic [BID_W-1:0]  tag_bid_o,
    output logic [EVID_W-1:0] tag_evid_o,
    output logic              mismatch_o,
    output logic [ERR_W-1:0]  err_cnt_o
);
    logic bclr;

    bxt_pulse_delay #(.DLY_W(DLY_W)) u_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pulse_i(bunch_rst_i),
        .dly_i  (bres_dly_i),
        .pulse_o(bclr)
    );

    bxt_counters #(.BID_W(BID_W), .ORBIT_LEN(ORBIT_LEN), .EVID_W(EVID_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bclr_i     (bclr),
        .eclr_i     (event_rst_i),
        .accept_i   (accept_i),
        .tag_valid_o(tag_valid_o),
        .tag_bid_o  (tag_bid_o),
        .tag_evid_o (tag_evid_o)
    );

    bxt_pair_check #(.BID_W(BID_W), .EVID_W(EVID_W), .ERR_W(ERR_W)) u_chk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .loc_bid_i  (tag_bid_o),
        .loc_evid_i (tag_evid_o),
        .hdr_valid_i(hdr_valid_i),
        .hdr_bid_i  (hdr_bid_i),
        .hdr_evid_i (hdr_evid_i),
        .clr_i      (err_clr_i),
        .mismatch_o (mismatch_o),
        .err_cnt_o  (err_cnt_o)
    );
endmodule

// File: tb/bx_evt_tagger_test.sv
`timescale 1ns/1ps
module bx_evt_tagger_test;
    localparam int BID_W = 12, ORBIT = 3564, EVID_W = 8, DLY_W = 4, ERR_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bres = 0, eres = 0, acc = 0, hv = 0, clr = 0;
    logic [DLY_W-1:0]  dly = '0;
    logic [BID_W-1:0]  hb = '0;
    logic [EVID_W-1:0] he = '0;
    logic              tv, mm;
    logic [BID_W-1:0]  tb;
    logic [EVID_W-1:0] te;
    logic [ERR_W-1:0]  ec;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bx_evt_tagger uut (
        .clk_i(clk), .rst_ni(rst_n), .bunch_rst_i(bres), .event_rst_i(eres),
        .bres_dly_i(dly), .accept_i(acc), .hdr_valid_i(hv), .hdr_bid_i(hb),
        .hdr_evid_i(he), .err_clr_i(clr), .tag_valid_o(tv), .tag_bid_o(tb),
        .tag_evid_o(te), .mismatch_o(mm), .err_cnt_o(ec)
    );

    // table: delay setting, expected bunch number of the tag
    localparam int NV = 8;
    localparam int VD [NV] = '{0, 0, 3, 15, 1, 7, 2, 15};
    localparam int VK [NV] = '{0, 5, 2, 7, 0, 100, 3, 0};

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        // R9 reset state
        chk("R9 tag_valid", tv, 0); chk("R9 tag_bid", tb, 0); chk("R9 tag_evid", te, 0);
        chk("R9 mismatch", mm, 0);  chk("R9 err_cnt", ec, 0);
        rst_n = 1;
        eres = 1; step(1); eres = 0;

        // table walk: R2 delay alignment, R5 capture, R3 event count
        for (int i = 0; i < NV; i++) begin
            dly = DLY_W'(VD[i]);
            bres = 1; step(1); bres = 0;
            step(VD[i] + VK[i]);
            acc = 1; step(1); acc = 0;
            chk("R5 tag_valid", tv, 1);
            chk("R2 tag_bid", tb, VK[i]);
            chk("R3 tag_evid", te, i);
            step(1);
            chk("R5 tag_valid low", tv, 0);
            chk("R5 tag_bid hold", tb, VK[i]);
        end

        // R6 matching header: last tag is bid 0, evid 7
        hv = 1; hb = 0; he = 7; step(1); hv = 0;
        chk("R6 match flag", mm, 0); chk("R7 match count", ec, 0);
        hv = 1; hb = 1; step(1); hv = 0;
        chk("R6 bad bid flag", mm, 1); chk("R7 count", ec, 1);
        step(5);
        chk("R6 sticky", mm, 1);
        clr = 1; step(1); clr = 0;
        chk("R8 cleared", mm, 0); chk("R8 count kept", ec, 1);
        hv = 1; hb = 0; he = 3; step(1); hv = 0;
        chk("R6 bad evid flag", mm, 1); chk("R7 count", ec, 2);
        clr = 1; hv = 1; step(1); clr = 0; hv = 0;
        chk("R8 set wins", mm, 1); chk("R7 count", ec, 3);
        clr = 1; step(1); clr = 0;
        hv = 1; he = 7; step(1); hv = 0;
        chk("R7 match keeps count", ec, 3); chk("R8 flag clear", mm, 0);

        // R4 event reset together with accept (current evid 8)
        eres = 1; acc = 1; step(1); eres = 0; acc = 0;
        chk("R4 pre-clear value", te, 8);
        acc = 1; step(1); acc = 0;
        chk("R4 after clear", te, 0);

        // R3 event number wrap
        eres = 1; step(1); eres = 0;
        acc = 1;
        for (int j = 1; j <= 257; j++) begin
            step(1);
            if (j == 256) chk("R3 last value", te, 255);
            if (j == 257) chk("R3 wrap", te, 0);
        end
        acc = 0;

        // R1 orbit wrap without further bunch reset
        dly = '0;
        bres = 1; step(1); bres = 0;
        step(ORBIT - 1);
        acc = 1; step(1);
        chk("R1 last bunch", tb, ORBIT - 1);
        step(1); acc = 0;
        chk("R1 wrap to zero", tb, 0);
        step(1);
        chk("R5 idle", tv, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule